// File: doc/BRIEF.md
# Watchdog-Bounded DMA Byte Relay

This block runs one DMA transfer from start to finish. A start pulse opens a request phase. The block raises its request line to the DMA resource and keeps it up until that resource acknowledges. It then enters a relay phase. In the relay phase every incoming byte strobe, with its data, is passed to the output side. An end-of-transfer strobe closes the relay phase and reports completion with a one-cycle done pulse.

An outer watchdog encloses both phases. It counts millisecond tick pulses from the moment the transfer starts. When the configured number of ticks has been counted, the transfer is cut short at once and a one-cycle timeout pulse is reported instead. Every abort takes priority over the body it ends, so the preempted phase does nothing in the cycle of the abort.

All outputs are registered. An input sampled at clock edge k is reflected on the outputs after that same edge, which means they are visible during cycle k+1. After a done pulse or a timeout pulse the block is idle again and waits for the next start.

Top module: `dma_relay_wd`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every output is low: request, byte-out valid, byte-out data, done and timeout.
- R2: A start sampled while idle makes the request output high from the next cycle. The request stays high on every cycle until an acknowledge is sampled. The request never rises without a start sampled one cycle earlier.
- R3: When an acknowledge is sampled during the request phase, the request output is low from the next cycle. The block then enters the relay phase.
- R4: In the relay phase, a byte-in valid sampled without end-of-transfer and without watchdog expiry gives byte-out valid on the next cycle, carrying the same data value. Bytes are passed one for one and in order.
- R5: An end-of-transfer sampled in the relay phase gives a done pulse exactly one cycle long on the next cycle, and the block returns to idle. A byte sampled in the same cycle as the end-of-transfer is not forwarded.
- R6: Ticks are counted only in cycles spent in the request or relay phase, and the count restarts from zero at each accepted start. The cycle in which the TICK_LIMIT-th tick is sampled (default 10) gives a timeout pulse exactly one cycle long on the next cycle, with the request low and the block idle. That expiry preempts an acknowledge, an end-of-transfer and a byte sampled in the same cycle: none of them acts, and no done pulse and no byte-out follow.
- R7: Inputs outside their own phase have no effect. While idle, acknowledge, end-of-transfer, bytes and ticks are ignored. In the request phase, end-of-transfer and bytes are ignored. In the relay phase, acknowledge is ignored. While busy, start is ignored and does not restart the tick count.
- R8: Done and timeout are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (acted on only while idle) |
| tick_i | input | 1 | One-cycle millisecond tick |
| ack_i | input | 1 | Acknowledge from the DMA resource |
| eot_i | input | 1 | End-of-transfer strobe |
| bin_vld_i | input | 1 | Incoming byte strobe |
| bin_data_i | input | DATA_W | Incoming byte value |
| req_o | output | 1 | DMA request, held through the request phase |
| bout_vld_o | output | 1 | Forwarded byte strobe |
| bout_data_o | output | DATA_W | Forwarded byte value |
| done_o | output | 1 | One-cycle pulse on normal completion |
| timeout_o | output | 1 | One-cycle pulse on watchdog expiry |

## Verification
The risky coincidences are cycles where the watchdog's final tick lands together with a phase-ending event. In one such cycle it meets an acknowledge in the request phase. In another it meets an end-of-transfer plus a byte in the relay phase. The bench places the tenth counted tick in exactly those cycles. It expects a timeout pulse with no done pulse, no forwarded byte and no entry into the relay phase. A second coincidence also gets its own cycle: an end-of-transfer arriving with a byte. There the bench expects a done pulse while the byte scoreboard stays empty.

// File: rtl/dma_relay_pkg.sv
package dma_relay_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_REQ   = 2'd1,
    PH_RELAY = 2'd2
  } phase_t;

endpackage

// File: rtl/dma_watchdog.sv
module dma_watchdog #(
  parameter int TICK_LIMIT = 10,
  localparam int CNT_W = $clog2(TICK_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expire
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  // expiry is seen in the very cycle of the last tick so it can preempt
  assign expire = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run && tick && !expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/dma_phase_ctrl.sv
module dma_phase_ctrl
  import dma_relay_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   ack,
  input  logic   eot,
  input  logic   expire,
  output phase_t phase,
  output phase_t phase_nxt,
  output logic   accept,
  output logic   fin,
  output logic   relay_open
);

  phase_t phase_q;

  assign phase      = phase_q;
  assign accept     = (phase_q == PH_IDLE) && start;
  // inner aborts are only honoured when the outer watchdog stays quiet
  assign fin        = (phase_q == PH_RELAY) && eot && !expire;
  assign relay_open = (phase_q == PH_RELAY) && !eot && !expire;

  always_comb begin
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start) phase_nxt = PH_REQ;
      PH_REQ: begin
        if (expire)   phase_nxt = PH_IDLE;
        else if (ack) phase_nxt = PH_RELAY;
      end
      PH_RELAY: if (expire || eot) phase_nxt = PH_IDLE;
      default:  phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_nxt;
  end

endmodule

// File: rtl/dma_byte_path.sv
module dma_byte_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);

  logic fwd;
  assign fwd = open && in_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= fwd;
      if (fwd) out_data <= in_data;
    end
  end

endmodule

// File: rtl/dma_relay_wd.sv
module dma_relay_wd
  import dma_relay_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int TICK_LIMIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              ack_i,
  input  logic              eot_i,
  input  logic              bin_vld_i,
  input  logic [DATA_W-1:0] bin_data_i,
  output logic              req_o,
  output logic              bout_vld_o,
  output logic [DATA_W-1:0] bout_data_o,
  output logic              done_o,
  output logic              timeout_o
);

  phase_t phase, phase_nxt;
  logic   accept, fin, relay_open, expire;

  dma_phase_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start_i),
    .ack        (ack_i),
    .eot        (eot_i),
    .expire     (expire),
    .phase      (phase),
    .phase_nxt  (phase_nxt),
    .accept     (accept),
    .fin        (fin),
    .relay_open (relay_open)
  );

  dma_watchdog #(.TICK_LIMIT(TICK_LIMIT)) u_wd (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .run    (phase != PH_IDLE),
    .tick   (tick_i),
    .expire (expire)
  );

  dma_byte_path #(.DATA_W(DATA_W)) u_bytes (
    .clk      (clk),
    .rst      (rst),
    .open     (relay_open),
    .in_vld   (bin_vld_i),
    .in_data  (bin_data_i),
    .out_vld  (bout_vld_o),
    .out_data (bout_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o     <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      req_o     <= (phase_nxt == PH_REQ);
      done_o    <= fin;
      timeout_o <= expire;
    end
  end

endmodule

// File: rtl/dma_relay_wd_chk.sv
module dma_relay_wd_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              ack_i,
  input logic              bin_vld_i,
  input logic [DATA_W-1:0] bin_data_i,
  input logic              req_o,
  input logic              bout_vld_o,
  input logic [DATA_W-1:0] bout_data_o,
  input logic              done_o,
  input logic              timeout_o
);

  // R2
  req_rise_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(start_i));

  // R3
  req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && ack_i) |=> !req_o);

  // R4
  byte_matches_input_chk: assert property (@(posedge clk) disable iff (rst)
    bout_vld_o |-> ($past(bin_vld_i) && bout_data_o == $past(bin_data_i)));

  // R5
  done_without_byte_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !bout_vld_o);

  // R5
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  timeout_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);

  // R6
  timeout_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (!req_o && !bout_vld_o));

  // R8
  done_timeout_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && timeout_o));

endmodule

bind dma_relay_wd dma_relay_wd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .ack_i       (ack_i),
  .bin_vld_i   (bin_vld_i),
  .bin_data_i  (bin_data_i),
  .req_o       (req_o),
  .bout_vld_o  (bout_vld_o),
  .bout_data_o (bout_data_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o)
);

// File: tb/dma_relay_wd_tb.sv
module dma_relay_wd_tb;

  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, tick_i = 0, ack_i = 0, eot_i = 0, bin_vld_i = 0;
  logic [DW-1:0] bin_data_i = '0;
  logic req_o, bout_vld_o, done_o, timeout_o;
  logic [DW-1:0] bout_data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  dma_relay_wd #(.DATA_W(DW), .TICK_LIMIT(10)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i), .ack_i(ack_i),
    .eot_i(eot_i), .bin_vld_i(bin_vld_i), .bin_data_i(bin_data_i),
    .req_o(req_o), .bout_vld_o(bout_vld_o), .bout_data_o(bout_data_o),
    .done_o(done_o), .timeout_o(timeout_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs; fwd pushes the byte as an expected output
  task automatic step(bit st, bit tk, bit ak, bit eo, bit bv,
                      logic [DW-1:0] bd, bit fwd);
    start_i = st; tick_i = tk; ack_i = ak; eot_i = eo;
    bin_vld_i = bv; bin_data_i = bd;
    if (fwd) exp_q.push_back(bd);
    @(posedge clk);
    #2;
    start_i = 0; tick_i = 0; ack_i = 0; eot_i = 0; bin_vld_i = 0;
  endtask

  task automatic outs(string tag, bit rq, bit dn, bit to);
    check({tag, " req"}, int'(req_o), int'(rq));
    check({tag, " done"}, int'(done_o), int'(dn));
    check({tag, " timeout"}, int'(timeout_o), int'(to));
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (!rst && bout_vld_o) begin
      if (exp_q.size() == 0) begin
        check("R4/R7 unexpected byte-out", int'(bout_data_o), -1);
      end else begin
        check("R4 byte data", int'(bout_data_o), int'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    outs("R1", 0, 0, 0);
    check("R1 bout_vld", int'(bout_vld_o), 0);
    check("R1 bout_data", int'(bout_data_o), 0);
    rst = 0;
    step(0, 0, 0, 0, 0, 8'h00, 0);
    outs("R1 post", 0, 0, 0);

    // R7: idle ignores ack, eot, bytes
    step(0, 1, 1, 1, 1, 8'h11, 0);
    outs("R7 idle", 0, 0, 0);

    // R2: start then hold
    step(1, 0, 0, 0, 0, 8'h00, 0);
    outs("R2 rise", 1, 0, 0);
    step(0, 0, 0, 1, 1, 8'h22, 0);
    outs("R7 eot/byte in request", 1, 0, 0);
    step(0, 0, 0, 0, 0, 8'h00, 0);
    outs("R2 hold", 1, 0, 0);

    // R3: ack ends request
    step(0, 0, 1, 0, 0, 8'h00, 0);
    outs("R3 ack", 0, 0, 0);

    // R4: relay with gaps
    step(0, 0, 0, 0, 1, 8'hA5, 1);
    step(0, 0, 0, 0, 0, 8'h00, 0);
    step(0, 0, 0, 0, 1, 8'h3C, 1);
    step(0, 0, 0, 0, 1, 8'hC3, 1);
    check("R4 back-to-back vld", int'(bout_vld_o), 1);
    step(1, 0, 1, 0, 1, 8'h5A, 1);
    outs("R7 start/ack in relay", 0, 0, 0);

    // R5: eot with byte
    step(0, 0, 0, 1, 1, 8'hFF, 0);
    outs("R5 done", 0, 1, 0);
    check("R5 byte dropped", int'(bout_vld_o), 0);
    step(0, 0, 0, 0, 1, 8'h77, 0);
    outs("R5 done pulse end", 0, 0, 0);

    // R6: timeout in request phase, ack preempted
    step(1, 1, 0, 0, 0, 8'h00, 0);
    for (int i = 1; i <= 9; i++) begin
      step(0, 1, 0, 0, 0, 8'h00, 0);
    end
    outs("R6 nine ticks", 1, 0, 0);
    step(0, 1, 1, 0, 0, 8'h00, 0);
    outs("R6 expire vs ack", 0, 0, 1);
    step(0, 0, 0, 0, 1, 8'h66, 0);
    outs("R6 pulse end", 0, 0, 0);
    check("R6 no relay after preempted ack", int'(bout_vld_o), 0);

    // R6/R7: timeout in relay, start while busy not restarting count
    step(1, 0, 0, 0, 0, 8'h00, 0);
    step(0, 1, 1, 0, 0, 8'h00, 0);
    for (int i = 2; i <= 5; i++) step(0, 1, 0, 0, 0, 8'h00, 0);
    step(1, 0, 0, 0, 0, 8'h00, 0);
    for (int i = 6; i <= 9; i++) step(0, 1, 0, 0, 0, 8'h00, 0);
    outs("R7 start ignored busy", 0, 0, 0);
    step(0, 1, 0, 1, 1, 8'h99, 0);
    outs("R6 R8 expire vs eot", 0, 0, 1);
    check("R6 byte preempted", int'(bout_vld_o), 0);
    step(0, 0, 0, 0, 0, 8'h00, 0);
    outs("R6 idle after", 0, 0, 0);

    // normal transfer after timeout
    step(1, 0, 0, 0, 0, 8'h00, 0);
    outs("R2 restart", 1, 0, 0);
    step(0, 0, 1, 0, 0, 8'h00, 0);
    step(0, 0, 0, 0, 1, 8'h12, 1);
    step(0, 0, 0, 1, 0, 8'h00, 0);
    outs("R5 second done", 0, 1, 0);
    step(0, 0, 0, 0, 0, 8'h00, 0);

    check("R4 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule